// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block sits next to a 32-bit processor core and performs the architectural state changes that happen when the core is reset or takes a general exception. On an accepted exception it saves the current program counter and status word, and raises the block, privilege and register-bank bits in the status word. It records an event code and issues a one-cycle redirect strobe carrying the handler address. The handler address is the vector base plus a fixed offset, and that offset is different for translation-miss faults.

Two resets are handled. Power-on reset is asynchronous and wins over everything else. Manual reset is sampled on the clock. Both put the status word, the vector base and the event register into their boot values and drive the reset-out and status pins. After reset is released, the block issues a redirect to the boot address. The core owns its live registers. It presents the current PC, SR and VBR on inputs, and it loads `sr_o`, `vbr_o`, `spc_o` and `ssr_o` back from this block when it sees the redirect.

The control is a three-state machine:
- `ST_RESET` is held while either reset is active.
- `ST_IDLE` waits for a request.
- `ST_REDIRECT` lasts one cycle and drives the strobe.

The transitions are:
- `ST_RESET` to `ST_REDIRECT` when the resets are released.
- `ST_IDLE` to `ST_REDIRECT` when a request is accepted.
- `ST_REDIRECT` to `ST_IDLE` always.
- Any state to `ST_RESET` when manual reset is low.
- Any state to `ST_RESET` at once when power-on reset is low.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On an accepted exception, `spc_o` takes `pc_i` and `ssr_o` takes `sr_i` as they were in the accepting cycle.
- R2: On an accepted exception, `sr_o` becomes `sr_i` with bit 28 (block), bit 29 (register bank) and bit 30 (privileged mode) set, and every other bit unchanged.
- R3: The handler address is `vbr_i` + 0x400 when `exc_tlb_miss` is 1 for a general request. It is `vbr_i` + 0x100 for every other general request and for an accepted NMI.
- R4: A general request loads `evt_o` with `exc_code`. An accepted NMI loads 0x1C0, and an NMI wins over a general request presented in the same cycle.
- R5: While `por_n` is low, without waiting for a clock, the outputs are: `evt_o` = 0x000, `vbr_o` = 0, `sr_o` = 0x700000F0 (bits 30..28 set, interrupt mask bits 7..4 all ones), `spc_o` = `ssr_o` = 0.
- R6: At each clock edge where `mrst_n` is low, `evt_o` becomes 0x020, `vbr_o` becomes 0 and `sr_o` becomes 0x700000F0. `spc_o` and `ssr_o` keep their values.
- R7: In the first cycle after both resets are released, `redirect_o` pulses with `target_o` = 0xA0000000.
- R8: While in reset, `rst_out_n` is 0 and `status_o` is 2'b11. Outside reset they are 1 and 2'b00.
- R9: Power-on reset overrides manual reset, and manual reset overrides any exception or NMI request in the same cycle.
- R10: A general request while `sr_i[28]` is 1 is ignored: there is no redirect and no output register changes.
- R11: An NMI with `sr_i[28]` = 1 is accepted only when `blmsk` is 1. With `sr_i[28]` = 0 it is always accepted.
- R12: `redirect_o` is high for exactly one cycle, the cycle after the accepting clock edge, with `target_o` valid in that cycle. Requests are accepted only in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, sampled on the clock |
| exc_req | input | 1 | General exception request |
| exc_tlb_miss | input | 1 | Request is a translation-miss fault |
| exc_code | input | 12 | Event code supplied with the request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| blmsk | input | 1 | Lets NMI pass while the block bit is set |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status word |
| vbr_i | input | 32 | Current vector base |
| spc_o | output | 32 | Saved program counter |
| ssr_o | output | 32 | Saved status word |
| sr_o | output | 32 | Updated status word |
| vbr_o | output | 32 | Vector base value to load |
| evt_o | output | 12 | Exception event register |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| target_o | output | 32 | New fetch address |
| rst_out_n | output | 1 | Reset-out pin, low during reset |
| status_o | output | 2 | Status pins, both high during reset |

## Verification
The bench checks both vector offsets and the boot address, including reset entered with a request pending; a design with the offsets or priority wrong would redirect to the wrong handler or record the request's code instead of 0x020. It raises general requests and NMIs with the block bit set, with and without the mask-enable bit; a design that ignored the block bit, or blocked NMI unconditionally, would produce a redirect the scoreboard did not expect, or miss one it did. It checks that the status word keeps its non-entry bits, and that the saved PC and SR survive a manual reset; a design that cleared them would fail the capture comparison.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int SR_W     = 32;
    localparam int SR_MD    = 30;
    localparam int SR_RB    = 29;
    localparam int SR_BL    = 28;
    localparam int SR_IM_LO = 4;
    localparam int SR_IM_W  = 4;

    typedef enum logic [1:0] {
        ST_RESET    = 2'd0,
        ST_IDLE     = 2'd1,
        ST_REDIRECT = 2'd2
    } ent_state_e;

    function automatic logic [SR_W-1:0] entry_bits();
        logic [SR_W-1:0] m;
        m        = '0;
        m[SR_MD] = 1'b1;
        m[SR_RB] = 1'b1;
        m[SR_BL] = 1'b1;
        return m;
    endfunction

    function automatic logic [SR_W-1:0] sr_boot_value();
        logic [SR_W-1:0] v;
        v = entry_bits();
        v[SR_IM_LO +: SR_IM_W] = '1;
        return v;
    endfunction

endpackage

// File: rtl/exc_accept.sv
module exc_accept
    import exc_entry_pkg::*;
#(
    parameter int           EVT_W   = 12,
    parameter logic [11:0]  EVT_NMI = 12'h1C0
) (
    input  logic             exc_req,
    input  logic             exc_tlb_miss,
    input  logic [EVT_W-1:0] exc_code,
    input  logic             nmi_req,
    input  logic             blmsk,
    input  logic             bl,
    output logic             take,
    output logic             use_tlb,
    output logic [EVT_W-1:0] evt_sel
);
    logic nmi_ok;
    logic gen_ok;

    always_comb begin
        nmi_ok  = nmi_req && (!bl || blmsk);
        gen_ok  = exc_req && !bl;
        take    = nmi_ok || gen_ok;
        use_tlb = !nmi_ok && exc_tlb_miss;
        evt_sel = nmi_ok ? EVT_NMI[EVT_W-1:0] : exc_code;
    end

    // R10, R11: with the block bit set, only an enabled NMI may pass
    always_comb begin
        a_r11_block_gate: assert (!(take && bl && !(nmi_req && blmsk)));
    end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
    parameter int               XLEN    = 32,
    parameter logic [XLEN-1:0]  TLB_OFS = 32'h0000_0400,
    parameter logic [XLEN-1:0]  GEN_OFS = 32'h0000_0100,
    parameter bit               OR_BASE = 1'b0
) (
    input  logic [XLEN-1:0] vbr,
    input  logic            use_tlb,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] ofs;

    assign ofs = use_tlb ? TLB_OFS : GEN_OFS;

    generate
        if (OR_BASE) begin : g_or_base
            assign target = vbr | ofs;
        end else begin : g_add_base
            assign target = vbr + ofs;
        end
    endgenerate

endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
    import exc_entry_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter int               EVT_W    = 12,
    parameter logic [XLEN-1:0]  BOOT_PC  = 32'hA000_0000,
    parameter logic [11:0]      EVT_POR  = 12'h000,
    parameter logic [11:0]      EVT_MRST = 12'h020
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ld_reset,
    input  logic             ld_exc,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [SR_W-1:0]  sr_i,
    input  logic [XLEN-1:0]  vbr_i,
    input  logic [EVT_W-1:0] evt_in,
    input  logic [XLEN-1:0]  vec_in,
    output logic [XLEN-1:0]  spc_q,
    output logic [SR_W-1:0]  ssr_q,
    output logic [SR_W-1:0]  sr_q,
    output logic [XLEN-1:0]  vbr_q,
    output logic [EVT_W-1:0] evt_q,
    output logic [XLEN-1:0]  target_q
);
    localparam logic [SR_W-1:0] SR_BOOT  = sr_boot_value();
    localparam logic [SR_W-1:0] SR_ENTRY = entry_bits();

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            spc_q    <= '0;
            ssr_q    <= '0;
            sr_q     <= SR_BOOT;
            vbr_q    <= '0;
            evt_q    <= EVT_POR[EVT_W-1:0];
            target_q <= BOOT_PC;
        end else if (ld_reset) begin
            sr_q     <= SR_BOOT;
            vbr_q    <= '0;
            evt_q    <= EVT_MRST[EVT_W-1:0];
            target_q <= BOOT_PC;
        end else if (ld_exc) begin
            spc_q    <= pc_i;
            ssr_q    <= sr_i;
            sr_q     <= sr_i | SR_ENTRY;
            vbr_q    <= vbr_i;
            evt_q    <= evt_in;
            target_q <= vec_in;
        end
    end

    a_r1_capture_pc: assert property (@(posedge clk) disable iff (!por_n)
        (ld_exc && !ld_reset) |=> (spc_q == $past(pc_i)) && (ssr_q == $past(sr_i)));

    a_r2_entry_bits: assert property (@(posedge clk) disable iff (!por_n)
        ld_exc |=> sr_q[SR_BL] && sr_q[SR_MD] && sr_q[SR_RB]);

    a_r6_manual_boot: assert property (@(posedge clk) disable iff (!por_n)
        ld_reset |=> (evt_q == EVT_MRST[EVT_W-1:0]) && (vbr_q == '0) && (target_q == BOOT_PC));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter int               EVT_W    = 12,
    parameter logic [XLEN-1:0]  BOOT_PC  = 32'hA000_0000,
    parameter logic [XLEN-1:0]  TLB_OFS  = 32'h0000_0400,
    parameter logic [XLEN-1:0]  GEN_OFS  = 32'h0000_0100,
    parameter logic [11:0]      EVT_POR  = 12'h000,
    parameter logic [11:0]      EVT_MRST = 12'h020,
    parameter logic [11:0]      EVT_NMI  = 12'h1C0,
    parameter bit               OR_BASE  = 1'b0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             mrst_n,
    input  logic             exc_req,
    input  logic             exc_tlb_miss,
    input  logic [EVT_W-1:0] exc_code,
    input  logic             nmi_req,
    input  logic             blmsk,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [31:0]      sr_i,
    input  logic [XLEN-1:0]  vbr_i,
    output logic [XLEN-1:0]  spc_o,
    output logic [31:0]      ssr_o,
    output logic [31:0]      sr_o,
    output logic [XLEN-1:0]  vbr_o,
    output logic [EVT_W-1:0] evt_o,
    output logic             redirect_o,
    output logic [XLEN-1:0]  target_o,
    output logic             rst_out_n,
    output logic [1:0]       status_o
);
    ent_state_e      state_q;
    ent_state_e      state_nx;
    logic            take;
    logic            use_tlb;
    logic [EVT_W-1:0] evt_sel;
    logic [XLEN-1:0] vec;
    logic            ld_reset;
    logic            ld_exc;

    exc_accept #(
        .EVT_W   (EVT_W),
        .EVT_NMI (EVT_NMI)
    ) u_accept (
        .exc_req      (exc_req),
        .exc_tlb_miss (exc_tlb_miss),
        .exc_code     (exc_code),
        .nmi_req      (nmi_req),
        .blmsk        (blmsk),
        .bl           (sr_i[SR_BL]),
        .take         (take),
        .use_tlb      (use_tlb),
        .evt_sel      (evt_sel)
    );

    exc_vector_gen #(
        .XLEN    (XLEN),
        .TLB_OFS (TLB_OFS),
        .GEN_OFS (GEN_OFS),
        .OR_BASE (OR_BASE)
    ) u_vec (
        .vbr     (vbr_i),
        .use_tlb (use_tlb),
        .target  (vec)
    );

    exc_ctx_regs #(
        .XLEN     (XLEN),
        .EVT_W    (EVT_W),
        .BOOT_PC  (BOOT_PC),
        .EVT_POR  (EVT_POR),
        .EVT_MRST (EVT_MRST)
    ) u_regs (
        .clk      (clk),
        .por_n    (por_n),
        .ld_reset (ld_reset),
        .ld_exc   (ld_exc),
        .pc_i     (pc_i),
        .sr_i     (sr_i),
        .vbr_i    (vbr_i),
        .evt_in   (evt_sel),
        .vec_in   (vec),
        .spc_q    (spc_o),
        .ssr_q    (ssr_o),
        .sr_q     (sr_o),
        .vbr_q    (vbr_o),
        .evt_q    (evt_o),
        .target_q (target_o)
    );

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_RESET;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RESET:    state_nx = mrst_n ? ST_REDIRECT : ST_RESET;
            ST_IDLE:     state_nx = !mrst_n ? ST_RESET : (take ? ST_REDIRECT : ST_IDLE);
            ST_REDIRECT: state_nx = !mrst_n ? ST_RESET : ST_IDLE;
            default:     state_nx = ST_RESET;
        endcase
    end

    // outputs and load strobes
    always_comb begin
        ld_reset   = !mrst_n;
        ld_exc     = (state_q == ST_IDLE) && mrst_n && take;
        redirect_o = (state_q == ST_REDIRECT);
        rst_out_n  = (state_q != ST_RESET);
        status_o   = (state_q == ST_RESET) ? 2'b11 : 2'b00;
    end

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
        redirect_o |=> !redirect_o);

    a_r10_blocked_no_redirect: assert property (@(posedge clk) disable iff (!por_n)
        ((state_q == ST_IDLE) && exc_req && !nmi_req && sr_i[SR_BL]) |=> !redirect_o);

    a_r9_manual_wins: assert property (@(posedge clk) disable iff (!por_n)
        !mrst_n |=> !rst_out_n && (status_o == 2'b11) && !redirect_o);

    a_r7_boot_redirect: assert property (@(posedge clk) disable iff (!por_n)
        ((state_q == ST_RESET) && mrst_n) |=> redirect_o && (target_o == BOOT_PC));

endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [31:0] target;
        logic [11:0] evt;
        logic [31:0] sr;
        logic [31:0] spc;
        logic [31:0] ssr;
        logic [31:0] vbr;
    } exp_t;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        mrst_n = 1'b1;
    logic        exc_req = 1'b0;
    logic        exc_tlb_miss = 1'b0;
    logic [11:0] exc_code = '0;
    logic        nmi_req = 1'b0;
    logic        blmsk = 1'b0;
    logic [31:0] pc_i = '0;
    logic [31:0] sr_i = '0;
    logic [31:0] vbr_i = '0;
    logic [31:0] spc_o, ssr_o, sr_o, vbr_o, target_o;
    logic [11:0] evt_o;
    logic        redirect_o, rst_out_n;
    logic [1:0]  status_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t expq[$];
    logic [31:0] last_spc = '0;
    logic [31:0] last_ssr = '0;

    exc_entry_ctrl dut_i (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .exc_req(exc_req),
        .exc_tlb_miss(exc_tlb_miss), .exc_code(exc_code), .nmi_req(nmi_req),
        .blmsk(blmsk), .pc_i(pc_i), .sr_i(sr_i), .vbr_i(vbr_i),
        .spc_o(spc_o), .ssr_o(ssr_o), .sr_o(sr_o), .vbr_o(vbr_o),
        .evt_o(evt_o), .redirect_o(redirect_o), .target_o(target_o),
        .rst_out_n(rst_out_n), .status_o(status_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!done && por_n && redirect_o === 1'b1) begin
            if (expq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10/R12: unexpected redirect actual target %h expected none", target_o);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk("R3/R7 target", target_o, e.target);
                chk("R4 event", {20'h0, evt_o}, {20'h0, e.evt});
                chk("R2 sr", sr_o, e.sr);
                chk("R1 spc", spc_o, e.spc);
                chk("R1 ssr", ssr_o, e.ssr);
                chk("R6 vbr", vbr_o, e.vbr);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive one request for one cycle; push expected entry if it should be taken
    task automatic request(input logic gen, input logic tlb, input logic [11:0] code,
                           input logic nmi, input logic msk, input logic [31:0] pc,
                           input logic [31:0] sr, input logic [31:0] vbr, input logic taken);
        exp_t e;
        @(negedge clk);
        exc_req = gen; exc_tlb_miss = tlb; exc_code = code; nmi_req = nmi;
        blmsk = msk; pc_i = pc; sr_i = sr; vbr_i = vbr;
        if (taken) begin
            e.target = vbr + ((tlb && !nmi) ? 32'h400 : 32'h100);
            e.evt    = nmi ? 12'h1C0 : code;
            e.sr     = sr | 32'h7000_0000;
            e.spc    = pc;
            e.ssr    = sr;
            e.vbr    = vbr;
            expq.push_back(e);
            last_spc = pc;
            last_ssr = sr;
        end
        @(negedge clk);
        exc_req = 1'b0; nmi_req = 1'b0; exc_tlb_miss = 1'b0;
        idle(3);
    endtask

    initial begin
        exp_t e;
        logic [11:0] evt_hold;
        // R5, R8: power-on reset state
        idle(3);
        chk("R5 evt", {20'h0, evt_o}, 32'h0);
        chk("R5 vbr", vbr_o, 32'h0);
        chk("R5 sr", sr_o, 32'h7000_00F0);
        chk("R5 spc", spc_o, 32'h0);
        chk("R8 rst_out_n", {31'h0, rst_out_n}, 32'h0);
        chk("R8 status", {30'h0, status_o}, 32'h3);
        chk("R8 redirect", {31'h0, redirect_o}, 32'h0);
        // R7: boot redirect after release
        e = '{target: 32'hA000_0000, evt: 12'h000, sr: 32'h7000_00F0, spc: 0, ssr: 0, vbr: 0};
        expq.push_back(e);
        por_n = 1'b1;
        idle(3);
        chk("R8 rst_out_n idle", {31'h0, rst_out_n}, 32'h1);
        chk("R8 status idle", {30'h0, status_o}, 32'h0);

        // R1 R2 R3 R4: general, non-TLB
        request(1, 0, 12'h160, 0, 0, 32'h0C00_1234, 32'h0000_0031, 32'h1234_5000, 1);
        // R3: TLB miss vector
        request(1, 1, 12'h040, 0, 0, 32'h8800_0010, 32'h4000_0000, 32'h8000_0000, 1);
        // R10: blocked general request, register state untouched
        evt_hold = evt_o;
        request(1, 0, 12'h0E0, 0, 0, 32'h1111_0000, 32'h1000_00F0, 32'h2000_0000, 0);
        chk("R10 evt unchanged", {20'h0, evt_o}, {20'h0, evt_hold});
        chk("R10 spc unchanged", spc_o, last_spc);
        // R11: NMI blocked without mask enable
        request(0, 0, 12'h000, 1, 0, 32'h2222_0000, 32'h1000_0000, 32'h3000_0000, 0);
        chk("R11 evt unchanged", {20'h0, evt_o}, {20'h0, evt_hold});
        // R11: NMI passes with mask enable
        request(0, 0, 12'h000, 1, 1, 32'h3333_0004, 32'h1000_0000, 32'h3000_0000, 1);
        // R11 + R4: NMI with BL clear wins over a TLB general request
        request(1, 1, 12'h0A0, 1, 0, 32'h4444_0008, 32'h0000_0001, 32'h0400_0000, 1);

        // R6, R9: manual reset while a request is pending
        @(negedge clk);
        mrst_n = 1'b0; exc_req = 1'b1; exc_code = 12'h0C0; sr_i = 32'h0;
        @(negedge clk);
        chk("R6 evt", {20'h0, evt_o}, 32'h20);
        chk("R6 vbr", vbr_o, 32'h0);
        chk("R6 sr", sr_o, 32'h7000_00F0);
        chk("R6 spc held", spc_o, last_spc);
        chk("R9 rst_out_n", {31'h0, rst_out_n}, 32'h0);
        chk("R9 status", {30'h0, status_o}, 32'h3);
        chk("R9 redirect", {31'h0, redirect_o}, 32'h0);
        e = '{target: 32'hA000_0000, evt: 12'h020, sr: 32'h7000_00F0,
              spc: last_spc, ssr: last_ssr, vbr: 0};
        expq.push_back(e);
        exc_req = 1'b0; mrst_n = 1'b1;
        idle(4);

        // R12: all expected redirects were produced exactly once
        chk("R12 scoreboard drained", expq.size(), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule